// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block is the device side of a flash-like read port. It holds a small register-file array and accepts a four-write command sequence on a write strobe. The sequence starts either a single-word program or a whole-array erase. While the operation is running, which takes a fixed number of clock cycles, a read does not return array contents. It returns a status word instead. The top bit is a completion indicator that depends on the operation kind and the data being programmed. The next bit flips on every read. The remaining bits read zero.

When the operation finishes, the array is updated. The first read after that point models the switch-over delay: it already carries the final value of the completion bit, but the flip bit is frozen and the low bits are not yet valid. Every read after that returns true array contents. A host can poll the block in either of two ways: compare the top bit against the value it expects, or read twice and watch whether the flip bit moves.

Top module: `embedded_status_port`

## Requirements
- R1: After synchronous reset, rd_valid and rd_data are 0 and every array word reads 8'hFF.
- R2: An operation starts only on the write strobe that follows three strobes carrying data 8'h3C, 8'hC3 and 8'h5A, in that order. The starting write's wr_erase (0 program, 1 erase), wr_addr and wr_data define it. A write with the wrong key returns the sequence to its first step. Before the starting write, reads return array data.
- R3: During a program operation, bit 7 of every read equals the inverse of bit 7 of the data being programmed.
- R4: During an erase operation, bit 7 of every read is 0.
- R5: During an operation, bit 6 is 1 on the first read and inverts on each further read.
- R6: During an operation, and on the first read after it ends, bits 5..0 read 0.
- R7: An operation lasts BUSY_CYCLES clock edges after the starting write. At completion a program stores wr_data at wr_addr, and an erase sets every word to 8'hFF.
- R8: The first read after completion returns bit 7 as the programmed data's bit 7 (program) or 1 (erase). Bit 6 repeats the value of the last busy read, or 0 if there was none.
- R9: From the second read after completion onward, reads return the addressed array word.
- R10: Write strobes while an operation runs are ignored. They neither start an operation nor advance the key sequence.
- R11: A read strobe produces rd_valid with rd_data on the clock edge that samples it, and rd_valid is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_stb | input | 1 | one-cycle write strobe |
| wr_addr | input | 3 | target word of the starting write |
| wr_data | input | 8 | key value or data to program |
| wr_erase | input | 1 | operation kind on the starting write: 1 erase, 0 program |
| rd_stb | input | 1 | one-cycle read strobe |
| rd_addr | input | 3 | word to read |
| rd_valid | output | 1 | read result valid |
| rd_data | output | 8 | array word or status word |

## Verification
The bench runs random programs and erases with random data, read counts and addresses. It targets several corner cases:
- A read with no busy read before the switch-over read. A flip bit that was not cleared at start would show here.
- A switch-over read whose flip bit must repeat the previous one. A design that keeps flipping, or that returns array data early, fails this.
- A programmed byte whose bit 7 is 0 or 1. An inverted or missing polarity flips the polled bit.
- A complete key sequence injected during a busy operation. It must neither retarget the array write nor leave the key counter advanced.
- A stalled sequence after three keys. A design that starts early would already report status.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int WORDS  = 1 << ADDR_W;

    localparam logic [DATA_W-1:0] KEY_A = 8'h3C;
    localparam logic [DATA_W-1:0] KEY_B = 8'hC3;
    localparam logic [DATA_W-1:0] KEY_C = 8'h5A;

    typedef enum logic { OP_PROG = 1'b0, OP_ERASE = 1'b1 } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } op_cmd_t;

    // completion bit: while running, the opposite of the final value
    function automatic logic poll_bit(op_cmd_t c, logic finished);
        logic fin;
        fin = (c.kind == OP_ERASE) ? 1'b1 : c.data[DATA_W-1];
        return finished ? fin : ~fin;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(logic poll, logic flip);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1] = poll;
        w[DATA_W-2] = flip;
        return w;
    endfunction
endpackage

// File: rtl/fsr_unlock.sv
module fsr_unlock
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_erase,
    input  logic              blocked,
    output logic              start,
    output op_cmd_t           cmd
);
    logic [1:0]        step;
    logic [DATA_W-1:0] want;
    logic              take;

    assign take = wr_stb && !blocked;

    always_comb begin
        unique case (step)
            2'd0:    want = KEY_A;
            2'd1:    want = KEY_B;
            default: want = KEY_C;
        endcase
    end

    assign start    = take && (step == 2'd3);
    assign cmd.kind = op_kind_e'(wr_erase);
    assign cmd.addr = wr_addr;
    assign cmd.data = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= 2'd0;
        end else if (take) begin
            if (step == 2'd3)         step <= 2'd0;
            else if (wr_data == want) step <= step + 2'd1;
            else                      step <= 2'd0;
        end
    end

    // R10: a busy period leaves the key sequence untouched
    assert_step_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        blocked |=> $stable(step));
endmodule

// File: rtl/fsr_timer.sv
module fsr_timer
    import fsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 200
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  op_cmd_t cmd_in,
    input  logic    rd_stb,
    output phase_e  phase,
    output op_cmd_t cmd_q,
    output logic    done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = (phase == PH_BUSY) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cmd_q <= '0;
        end else if (start) begin
            phase <= PH_BUSY;
            cnt   <= LOAD;
            cmd_q <= cmd_in;
        end else begin
            unique case (phase)
                PH_BUSY: begin
                    if (cnt == '0) phase <= PH_SETTLE;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_SETTLE: if (rd_stb) phase <= PH_IDLE;
                default: ;
            endcase
        end
    end

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BUSY && cnt != '0) |=> phase == PH_BUSY);
    assert_settle_follows_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> phase == PH_SETTLE);
    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BUSY) |=> $stable(cmd_q));
    assert_start_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> phase != PH_BUSY);
endmodule

// File: rtl/fsr_array.sv
module fsr_array
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  op_cmd_t           cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '1;
            end else if (commit) begin
                if (cmd.kind == OP_ERASE)            words[i] <= '1;
                else if (cmd.addr == ADDR_W'(i))     words[i] <= cmd.data;
            end
        end
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/embedded_status_port.sv
module embedded_status_port
    import fsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_erase,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    phase_e            phase;
    op_cmd_t           cmd_new;
    op_cmd_t           cmd_q;
    logic              start;
    logic              done;
    logic              flip;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] next_data;

    fsr_unlock u_unlock (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_erase(wr_erase),
        .blocked(phase == PH_BUSY), .start(start), .cmd(cmd_new)
    );

    fsr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_new),
        .rd_stb(rd_stb), .phase(phase), .cmd_q(cmd_q), .done(done)
    );

    fsr_array u_array (
        .clk(clk), .rst(rst), .commit(done), .cmd(cmd_q),
        .rd_addr(rd_addr), .rd_word(arr_word)
    );

    always_comb begin
        unique case (phase)
            PH_BUSY:   next_data = status_word(poll_bit(cmd_q, 1'b0), ~flip);
            PH_SETTLE: next_data = status_word(poll_bit(cmd_q, 1'b1), flip);
            default:   next_data = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flip     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= next_data;
            if (start)
                flip <= 1'b0;
            else if (rd_stb && phase == PH_BUSY)
                flip <= ~flip;
        end
    end

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);
    assert_valid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);
    assert_flip_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && phase == PH_BUSY && !start) |=> flip != $past(flip));
    assert_flip_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_BUSY && !start) |=> $stable(flip));
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && phase == PH_BUSY && cmd_q.kind == OP_ERASE) |=> !rd_data[DATA_W-1]);
endmodule

// File: tb/test_embedded_status_port.sv
module test_embedded_status_port;
    localparam int BUSY = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_erase = 1'b0;
    logic       rd_stb = 1'b0;
    logic [2:0] rd_addr = '0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] mem_m [8];

    embedded_status_port #(.BUSY_CYCLES(BUSY)) i_embedded_status_port (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_erase(wr_erase), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] busy_word(logic erase, logic [7:0] d, logic tg);
        return {(erase ? 1'b0 : ~d[7]), tg, 6'b0};
    endfunction

    function automatic logic [7:0] settle_word(logic erase, logic [7:0] d, logic tg);
        return {(erase ? 1'b1 : d[7]), tg, 6'b0};
    endfunction

    task automatic wr(logic [2:0] a, logic [7:0] d, logic er);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; wr_erase = er;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] q);
        rd_stb = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        total++;
        if (rd_valid !== 1'b1) begin
            bad++;
            $display("FAIL R11: actual=%b expected=1", rd_valid);
        end
        q = rd_data;
    endtask

    task automatic run_op(logic er, logic [2:0] a, logic [7:0] d, int nreads,
                          bit inject, bit stall_check);
        logic [7:0] q;
        logic       tg;
        logic [2:0] ra;
        wr(3'd0, 8'h3C, 1'b0);
        wr(3'd0, 8'hC3, 1'b0);
        wr(3'd0, 8'h5A, 1'b0);
        if (stall_check) begin
            ra = 3'($urandom);
            rd(ra, q);
            check("R2 no status before starting write", q, mem_m[ra]);
        end
        wr(a, d, er);
        tg = 1'b0;
        for (int i = 0; i < nreads; i++) begin
            ra = 3'($urandom);
            rd(ra, q);
            tg = ~tg;
            check(er ? "R4 R5 R6 erase busy word" : "R3 R5 R6 program busy word",
                  q, busy_word(er, d, tg));
            if (inject && i == 0) begin
                wr(3'd0, 8'h3C, 1'b0);
                wr(3'd0, 8'hC3, 1'b0);
                wr(3'd0, 8'h5A, 1'b0);
                wr(~a, ~d, ~er);
            end
        end
        repeat (BUSY + 5) @(negedge clk);
        if (er) begin
            for (int k = 0; k < 8; k++) mem_m[k] = 8'hFF;
        end else begin
            mem_m[a] = d;
        end
        ra = 3'($urandom);
        rd(ra, q);
        check("R8 R6 switch-over read", q, settle_word(er, d, tg));
        ra = 3'($urandom);
        rd(ra, q);
        check("R9 R7 array data after completion", q, mem_m[ra]);
        rd(a, q);
        check("R7 R10 target word", q, mem_m[a]);
    endtask

    initial begin
        logic [7:0] q;
        void'($urandom(32'd2024));
        for (int k = 0; k < 8; k++) mem_m[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rd_valid after reset", {7'b0, rd_valid}, 8'h00);
        check("R1 rd_data after reset", rd_data, 8'h00);
        @(negedge clk);
        check("R11 no valid without strobe", {7'b0, rd_valid}, 8'h00);
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), q);
            check("R1 erased array", q, 8'hFF);
        end

        // wrong key resets the sequence: nothing starts
        wr(3'd0, 8'h3C, 1'b0);
        wr(3'd0, 8'hC3, 1'b0);
        wr(3'd0, 8'h11, 1'b0);
        wr(3'd2, 8'h00, 1'b0);
        rd(3'd2, q);
        check("R2 wrong key no start", q, 8'hFF);
        repeat (BUSY + 5) @(negedge clk);
        rd(3'd2, q);
        check("R2 wrong key array unchanged", q, 8'hFF);

        // directed corners
        run_op(1'b0, 3'd1, 8'h35, 0, 1'b0, 1'b1);
        run_op(1'b0, 3'd2, 8'hC4, 3, 1'b1, 1'b0);
        run_op(1'b1, 3'd0, 8'h00, 4, 1'b0, 1'b0);
        run_op(1'b1, 3'd5, 8'h00, 0, 1'b1, 1'b1);

        // random mix
        for (int n = 0; n < 20; n++) begin
            run_op(1'($urandom % 4 == 0), 3'($urandom), 8'($urandom),
                   int'($urandom % 9), 1'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule